// File: doc/BRIEF.md
# Backlight Enable and Dimming Controller

This block drives the enable and the dimming input of a cold-cathode lamp inverter from a fast system clock. A backlight-on request starts a timed power-up. A dimming-source select picks either an external PWM waveform or a PWM generator inside the block. A digital brightness level sets the duty of that internal generator.

The controller enforces a few ordering rules. The source select is captured while the lamp is dark and stays frozen until the lamp is fully off again. The inverter enable rises only after a fixed delay from the request. After a shutdown, a minimum dark interval must pass before the next power-up can begin. The internal duty never drops below twenty percent. The inverter's analog drive, its high-voltage stage and any lamp-strike detection are handled elsewhere.

All delays and the PWM period are parameters counted in system-clock cycles. The defaults give half-second windows and roughly 160 Hz at a 100 MHz clock. Shorter values can be used in simulation.

Top module: `bl_dim_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, `inv_enable` and `dim_pwm` are low.
- R2: `inv_enable` goes high after ON_DLY_CYC further rising edges, counted from the edge that first samples `bl_on_req` high in the dark state. It is seen high after the (ON_DLY_CYC+1)-th edge, counting that sampling edge as the first.
- R3: When `bl_on_req` is sampled low during power-up or while lit, `inv_enable` is low after that edge and stays low. A power-up that is cut short this way never enables the inverter.
- R4: Once the request is sampled low, the dark-hold window lasts OFF_HOLD_CYC edges before a new power-up may begin. A request that is raised again straight after the drop shows `inv_enable` high on the (OFF_HOLD_CYC+ON_DLY_CYC+2)-th edge, counting the drop-sampling edge as the first.
- R5: In internal mode, each PWM period of PERIOD_CYC cycles holds `dim_pwm` high for floor(E*PERIOD_CYC/255) cycles, where E is the effective 8-bit level.
- R6: E equals `bright_lvl` when that is at least 51 (20% of 255, rounded up). Otherwise E is 51.
- R7: A select value of 1 means external mode. In that mode, `dim_pwm` equals `ext_pwm_in` from one cycle earlier while lit. A value of 0 means internal mode.
- R8: The select is taken from `dim_ext_sel` on the edge that starts a power-up. Changes on `dim_ext_sel` at any time outside the dark state have no effect on `dim_pwm`.
- R9: In internal mode, `ext_pwm_in` has no effect on `dim_pwm`. In external mode, `bright_lvl` has no effect on `dim_pwm`.
- R10: A new `bright_lvl` takes effect only at the start of a PWM period. Each high pulse has the width set by either the old level or the new one, never a width in between.
- R11: `dim_pwm` is high only in a cycle that directly follows a cycle in which `inv_enable` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bl_on_req | input | 1 | Backlight-on request |
| dim_ext_sel | input | 1 | Dimming source: 1 external, 0 internal |
| ext_pwm_in | input | 1 | External dimming waveform |
| bright_lvl | input | 8 | Brightness level for the internal generator |
| inv_enable | output | 1 | Inverter enable |
| dim_pwm | output | 1 | Dimming PWM to the inverter |

## Verification
The hardest case to reach is a brightness change that lands in the low part of a PWM period. Only a design that loads the level at the period start keeps the next pulse at its clean width. The stimulus waits for a falling edge of `dim_pwm`, waits a few more cycles, and then writes a much larger level. It then measures the width of the next high pulse. A second awkward case is a request that is raised again inside the dark-hold window. The bench drops and reasserts the request on consecutive cycles and counts the edges until the enable rises again.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;

    typedef enum logic [1:0] {
        ST_DARK    = 2'd0,
        ST_RAMP    = 2'd1,
        ST_LIT     = 2'd2,
        ST_COOL    = 2'd3
    } bl_state_e;

    // smallest level that still meets a duty floor given in percent
    function automatic int floor_level(input int pct, input int lvl_max);
        return (pct * lvl_max + 99) / 100;
    endfunction

endpackage

// File: rtl/bl_seq_fsm.sv
module bl_seq_fsm
    import bl_dim_pkg::*;
#(
    parameter int ON_DLY_CYC   = 50_000_000,
    parameter int OFF_HOLD_CYC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic sel_in,
    output logic lamp_on,
    output logic sel_ext
);

    localparam int MAX_DLY = (ON_DLY_CYC > OFF_HOLD_CYC) ? ON_DLY_CYC : OFF_HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_DLY_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_HOLD_CYC - 1);

    typedef struct packed {
        bl_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             sel;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_DARK: begin
                // select tracks the pin only while dark; the request edge captures it
                seq_d.sel = sel_in;
                seq_d.cnt = '0;
                if (on_req) begin
                    seq_d.st = ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (!on_req) begin
                    seq_d.st  = ST_COOL;
                    seq_d.cnt = '0;
                end else if (seq_q.cnt == ON_LAST) begin
                    seq_d.st  = ST_LIT;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_LIT: begin
                if (!on_req) begin
                    seq_d.st  = ST_COOL;
                    seq_d.cnt = '0;
                end
            end
            ST_COOL: begin
                if (seq_q.cnt == OFF_LAST) begin
                    seq_d.st  = ST_DARK;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.st  = ST_DARK;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_DARK;
            seq_q.cnt <= '0;
            seq_q.sel <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign lamp_on = (seq_q.st == ST_LIT);
    assign sel_ext = seq_q.sel;

endmodule

// File: rtl/bl_int_pwm.sv
module bl_int_pwm
    import bl_dim_pkg::*;
#(
    parameter int PERIOD_CYC = 625_000,
    parameter int LVL_W      = 8,
    parameter int MIN_PCT    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LVL_W-1:0] level,
    output logic             pwm
);

    localparam int LVL_MAX = (1 << LVL_W) - 1;
    localparam int MIN_LVL = floor_level(MIN_PCT, LVL_MAX);
    localparam int PW      = $clog2(PERIOD_CYC + 1);
    localparam int MW      = LVL_W + PW;
    localparam logic [PW-1:0] CNT_LAST = PW'(PERIOD_CYC - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] thr;
    } pwm_t;

    pwm_t pwm_d, pwm_q;

    logic [LVL_W-1:0] lvl_eff;
    logic [MW-1:0]    prod;
    logic [PW-1:0]    thr_new;

    always_comb begin
        lvl_eff = (level < LVL_W'(MIN_LVL)) ? LVL_W'(MIN_LVL) : level;
        prod    = MW'(lvl_eff) * MW'(PERIOD_CYC);
        thr_new = PW'(prod / MW'(LVL_MAX));
    end

    always_comb begin
        pwm_d = pwm_q;
        if (!run) begin
            pwm_d.cnt = '0;
            pwm_d.thr = thr_new;
        end else if (pwm_q.cnt == CNT_LAST) begin
            // level is sampled only here, at the period boundary
            pwm_d.cnt = '0;
            pwm_d.thr = thr_new;
        end else begin
            pwm_d.cnt = pwm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q.cnt <= '0;
            pwm_q.thr <= '0;
        end else begin
            pwm_q <= pwm_d;
        end
    end

    assign pwm = run && (pwm_q.cnt < pwm_q.thr);

endmodule

// File: rtl/bl_dim_mux.sv
module bl_dim_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic lamp_on,
    input  logic sel_ext,
    input  logic ext_pwm,
    input  logic int_pwm,
    output logic dim_out
);

    logic ext_gated;
    logic int_gated;
    logic dim_d, dim_q;

    always_comb begin
        // the unused path is forced to its idle level before combining
        ext_gated = ext_pwm & sel_ext;
        int_gated = int_pwm & ~sel_ext;
        dim_d     = lamp_on & (ext_gated | int_gated);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dim_q <= 1'b0;
        end else begin
            dim_q <= dim_d;
        end
    end

    assign dim_out = dim_q;

endmodule

// File: rtl/bl_dim_ctrl.sv
module bl_dim_ctrl #(
    parameter int ON_DLY_CYC   = 50_000_000,
    parameter int OFF_HOLD_CYC = 50_000_000,
    parameter int PERIOD_CYC   = 625_000,
    parameter int LVL_W        = 8,
    parameter int MIN_PCT      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bl_on_req,
    input  logic             dim_ext_sel,
    input  logic             ext_pwm_in,
    input  logic [LVL_W-1:0] bright_lvl,
    output logic             inv_enable,
    output logic             dim_pwm
);

    logic lamp_on;
    logic sel_ext;
    logic int_run;
    logic int_pwm;

    bl_seq_fsm #(
        .ON_DLY_CYC  (ON_DLY_CYC),
        .OFF_HOLD_CYC(OFF_HOLD_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .on_req (bl_on_req),
        .sel_in (dim_ext_sel),
        .lamp_on(lamp_on),
        .sel_ext(sel_ext)
    );

    assign int_run = lamp_on & ~sel_ext;

    bl_int_pwm #(
        .PERIOD_CYC(PERIOD_CYC),
        .LVL_W     (LVL_W),
        .MIN_PCT   (MIN_PCT)
    ) u_pwm (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (int_run),
        .level(bright_lvl),
        .pwm  (int_pwm)
    );

    bl_dim_mux u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .lamp_on(lamp_on),
        .sel_ext(sel_ext),
        .ext_pwm(ext_pwm_in),
        .int_pwm(int_pwm),
        .dim_out(dim_pwm)
    );

    assign inv_enable = lamp_on;

endmodule

// File: rtl/bl_dim_chk.sv
module bl_dim_chk #(
    parameter int ON_DLY_CYC   = 50_000_000,
    parameter int OFF_HOLD_CYC = 50_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic bl_on_req,
    input logic ext_pwm_in,
    input logic inv_enable,
    input logic dim_pwm,
    input logic sel_q
);

    localparam int RW = $clog2(ON_DLY_CYC + 1);
    localparam int DW = $clog2(OFF_HOLD_CYC + 1);

    logic [RW-1:0] req_run;
    logic [DW-1:0] dark_run;

    // consecutive cycles with the request high, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_run <= '0;
        end else if (!bl_on_req) begin
            req_run <= '0;
        end else if (req_run != RW'(ON_DLY_CYC)) begin
            req_run <= req_run + 1'b1;
        end
    end

    // consecutive dark cycles, starting saturated out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dark_run <= DW'(OFF_HOLD_CYC);
        end else if (inv_enable) begin
            dark_run <= '0;
        end else if (dark_run != DW'(OFF_HOLD_CYC)) begin
            dark_run <= dark_run + 1'b1;
        end
    end

    p_on_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_enable) |-> (req_run >= RW'(ON_DLY_CYC)));

    p_drop_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bl_on_req |=> !inv_enable);

    p_dark_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_enable) |-> (dark_run >= DW'(OFF_HOLD_CYC)));

    p_ext_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_enable) && $past(sel_q)) |-> (dim_pwm == $past(ext_pwm_in)));

    p_sel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_enable && $past(inv_enable)) |-> $stable(sel_q));

    p_dark_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dim_pwm |-> $past(inv_enable));

endmodule

bind bl_dim_ctrl bl_dim_chk #(
    .ON_DLY_CYC  (ON_DLY_CYC),
    .OFF_HOLD_CYC(OFF_HOLD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bl_on_req (bl_on_req),
    .ext_pwm_in(ext_pwm_in),
    .inv_enable(inv_enable),
    .dim_pwm   (dim_pwm),
    .sel_q     (sel_ext)
);

// File: tb/sim_bl_dim_ctrl.sv
module sim_bl_dim_ctrl;

    localparam int ON_D  = 8;
    localparam int OFF_H = 12;
    localparam int PER   = 50;
    localparam int NVEC  = 9;

    // {sel[17], ext[16], level[15:8], expected highs per period[7:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'd255, 8'd50},
        {1'b0, 1'b1, 8'd200, 8'd39},
        {1'b0, 1'b0, 8'd128, 8'd25},
        {1'b0, 1'b1, 8'd51,  8'd10},
        {1'b0, 1'b0, 8'd50,  8'd10},
        {1'b0, 1'b1, 8'd0,   8'd10},
        {1'b1, 1'b1, 8'd0,   8'd50},
        {1'b1, 1'b0, 8'd128, 8'd0},
        {1'b1, 1'b1, 8'd255, 8'd50}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bl_on_req;
    logic       dim_ext_sel;
    logic       ext_pwm_in;
    logic [7:0] bright_lvl;
    logic       inv_enable;
    logic       dim_pwm;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bl_dim_ctrl #(
        .ON_DLY_CYC  (ON_D),
        .OFF_HOLD_CYC(OFF_H),
        .PERIOD_CYC  (PER)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bl_on_req  (bl_on_req),
        .dim_ext_sel(dim_ext_sel),
        .ext_pwm_in (ext_pwm_in),
        .bright_lvl (bright_lvl),
        .inv_enable (inv_enable),
        .dim_pwm    (dim_pwm)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(output int h);
        h = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (dim_pwm) h++;
        end
    endtask

    // width of the next complete high pulse
    task automatic pulse_width(output int w);
        int g;
        w = 0;
        g = 0;
        while (dim_pwm && g < 4 * PER) begin @(negedge clk); g++; end
        while (!dim_pwm && g < 8 * PER) begin @(negedge clk); g++; end
        while (dim_pwm && w < 4 * PER) begin @(negedge clk); w++; end
    endtask

    task automatic power_up(input logic s);
        dim_ext_sel = s;
        bl_on_req   = 1'b1;
        tick(ON_D + 3);
    endtask

    task automatic power_down();
        bl_on_req = 1'b0;
        tick(OFF_H + 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        int h;
        int w;
        logic cur_sel;
        logic seen;

        rst_n       = 1'b0;
        bl_on_req   = 1'b0;
        dim_ext_sel = 1'b0;
        ext_pwm_in  = 1'b0;
        bright_lvl  = 8'd0;
        tick(3);
        check("R1 enable in reset", int'(inv_enable), 0);
        check("R1 pwm in reset", int'(dim_pwm), 0);
        rst_n = 1'b1;
        tick(4);
        check("R1 enable idle", int'(inv_enable), 0);

        // R2: exact power-up delay
        bl_on_req = 1'b1;
        cnt = 0;
        while (!inv_enable && cnt < 100) begin @(negedge clk); cnt++; end
        check("R2 on delay edges", cnt, ON_D + 1);
        tick(2);
        cur_sel = 1'b0;

        // table walk: R5 duty, R6 clamp, R7 external, R9 unused input
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][17] != cur_sel) begin
                power_down();
                power_up(VEC[v][17]);
                cur_sel = VEC[v][17];
            end
            ext_pwm_in = VEC[v][16];
            bright_lvl = VEC[v][15:8];
            tick(2 * PER + 2);
            count_high(h);
            if (VEC[v][17])
                check($sformatf("R7 R9 external vector %0d", v), h, int'(VEC[v][7:0]));
            else if (VEC[v][15:8] < 8'd51)
                check($sformatf("R6 clamp vector %0d", v), h, int'(VEC[v][7:0]));
            else
                check($sformatf("R5 R9 internal vector %0d", v), h, int'(VEC[v][7:0]));
        end

        // R7: one-cycle latency of the external path
        ext_pwm_in = 1'b0;
        tick(2);
        ext_pwm_in = 1'b1;
        @(negedge clk);
        check("R7 external latency", int'(dim_pwm), 1);

        // R8: select change while lit is ignored
        power_down();
        power_up(1'b0);
        bright_lvl = 8'd51;
        ext_pwm_in = 1'b1;
        tick(2);
        dim_ext_sel = 1'b1;
        tick(2 * PER);
        count_high(h);
        check("R8 select frozen", h, 10);

        // R10: level change in the low phase waits for the period start
        pulse_width(w);
        check("R10 width before change", w, 10);
        while (dim_pwm) @(negedge clk);
        tick(5);
        bright_lvl = 8'd200;
        pulse_width(w);
        check("R10 first new pulse", w, 39);
        pulse_width(w);
        check("R10 second new pulse", w, 39);

        // R3 and R11: drop while lit
        bl_on_req = 1'b0;
        @(negedge clk);
        check("R3 enable drops", int'(inv_enable), 0);
        @(negedge clk);
        check("R11 pwm quiet when dark", int'(dim_pwm), 0);
        tick(OFF_H + 3);

        // R8: dark state tracks select, external after power-up
        power_up(1'b1);
        tick(2);
        count_high(h);
        check("R8 select captured high", h, PER);

        // R4: reassert right after drop
        bl_on_req = 1'b0;
        @(negedge clk);
        cnt = 1;
        bl_on_req = 1'b1;
        while (!inv_enable && cnt < 200) begin @(negedge clk); cnt++; end
        check("R4 hold then ramp edges", cnt, OFF_H + ON_D + 2);

        // R3: aborted power-up never enables
        power_down();
        bl_on_req = 1'b1;
        tick(4);
        bl_on_req = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (inv_enable) seen = 1'b1;
        end
        check("R3 aborted ramp", int'(seen), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule